// File: doc/BRIEF.md
# Per-Context Stall and Delay Controller

This block sits beside the issue arbiter of a processor that interleaves eight hardware contexts. Each clock cycle the arbiter grants at most one context an issue slot. The controller decides, for that context only, whether its current instruction completes or whether the context must keep re-issuing the same instruction. The other contexts are never blocked by it.

Two kinds of stall are handled. A bit-wait keeps a context parked until a chosen bit reaches a target level, 0 or 1. The bit comes either from the sampled input port or from the shared general-purpose register that contexts use to signal each other. One context can flip a bit of that register while another waits on it. A counted delay parks a context for 0 to 255 of its own granted slots, so the wall-clock length of a delay scales with the share of slots the context receives. The controller keeps a busy flag, a latched wait condition and a down-counter for every context. It touches the state of a context only in that context's granted slot, or when that context is reset.

Top module: `ctx_stall_ctrl`

## Requirements
- R1: While `rstN` is low, and in the cycle after it rises, `holdOut` is all zeros.
- R2: A wait request is issued in a slot of a context that is not held. If the selected bit already equals the target level (wait-low: `reqKind`=1, target 0; wait-high: `reqKind`=2, target 1), that context's `holdOut` bit stays 0.
- R3: A wait-low request whose selected bit is 1 sets that context's `holdOut` bit on the next edge. The bit stays set until a granted slot of that context samples the bit as 0, and it clears on the edge that ends that slot.
- R4: A wait-high request behaves like R3 with the target level 1.
- R5: `reqSrc`=0 selects `portIn` and `reqSrc`=1 selects `sharedReg`. `reqBit` gives the bit index. Source and index are latched at issue and reused for every later evaluation.
- R6: A delay request (`reqKind`=3) with count N from 1 to 255 sets that context's `holdOut` bit. The bit stays set through exactly N further granted slots of that context and clears on the edge that ends the Nth.
- R7: A delay request with count 0 completes in its own slot and leaves `holdOut` at 0.
- R8: Wait conditions are sampled only in the waiting context's granted slots. A bit change that is gone again before that context's next slot does not release it.
- R9: A slot granted to one context never changes the `holdOut` bit of any other context.
- R10: While a context is held, the request fields presented in its slots are ignored.
- R11: A high `ctxRst` bit clears that context's pending wait or delay, and its `holdOut` bit is 0 on the next edge. A context reset takes priority over a request in the same cycle.
- R12: When `slotValid` is low and no context reset is active, `holdOut` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ctxRst | input | 8 | Per-context synchronous clear of pending stalls |
| slotValid | input | 1 | An issue slot is granted this cycle |
| slotCtx | input | 3 | Index of the granted context |
| reqKind | input | 2 | 0 none, 1 wait-low, 2 wait-high, 3 delay |
| reqSrc | input | 1 | Wait source: 0 input port, 1 shared register |
| reqBit | input | 3 | Bit index tested by a wait |
| reqCount | input | 8 | Delay length in own slots |
| portIn | input | 8 | Sampled input port bits |
| sharedReg | input | 8 | Shared inter-context register value |
| holdOut | output | 8 | Per-context hold: set means the context's slot must not advance |

## Verification
The checker assumes that the request fields describe the instruction of the granted context, and that a context whose hold bit is set is still given slots so that its condition can be re-evaluated. It also assumes that all inputs are steady across each rising edge. The stimulus changes every input shortly after a rising edge and grants only the contexts that the scenario exercises. Bits of the port and of the shared register are changed in slots that belong to other contexts, which exercises the rule that a condition is sampled only in the waiting context's own slot.

// File: rtl/ctx_stall_pkg.sv
package ctx_stall_pkg;
  localparam int NCTX = 8;
  localparam int DW   = 8;
  localparam int CNTW = 8;
  localparam int CW   = $clog2(NCTX);
  localparam int BW   = $clog2(DW);

  typedef enum logic [1:0] {
    REQ_NONE    = 2'd0,
    REQ_WAIT_LO = 2'd1,
    REQ_WAIT_HI = 2'd2,
    REQ_DELAY   = 2'd3
  } reqKind_e;

  // Strobes from the control to the per-context state
  typedef struct packed {
    logic          start;   // begin a stall for ctx
    logic          finish;  // release ctx
    logic          step;    // decrement ctx delay counter
    logic [CW-1:0] ctx;
  } stallStrobe_t;
endpackage

// File: rtl/ctx_stall_dp.sv
module ctx_stall_dp
  import ctx_stall_pkg::*;
#(
  parameter int NCTX_P = NCTX,
  parameter int DW_P   = DW,
  parameter int CNTW_P = CNTW,
  localparam int CW_P  = $clog2(NCTX_P),
  localparam int BW_P  = $clog2(DW_P)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NCTX_P-1:0] ctxRst,
  input  stallStrobe_t      strobe,
  input  logic [CW_P-1:0]   selCtx,
  input  logic [1:0]        reqKind,
  input  logic              reqSrc,
  input  logic [BW_P-1:0]   reqBit,
  input  logic [CNTW_P-1:0] reqCount,
  output logic [NCTX_P-1:0] busyVec,
  output logic              selBusy,
  output logic              selIsDelay,
  output logic              selPol,
  output logic              selSrc,
  output logic [BW_P-1:0]   selBit,
  output logic [CNTW_P-1:0] selCnt
);
  logic [NCTX_P-1:0] isDelayQ, polQ, srcQ;
  logic [BW_P-1:0]   bitQ [NCTX_P];
  logic [CNTW_P-1:0] cntQ [NCTX_P];

  for (genvar c = 0; c < NCTX_P; c++) begin : g_ctx
    logic hit;
    assign hit = (strobe.ctx == CW_P'(c));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        busyVec[c]  <= 1'b0;
        isDelayQ[c] <= 1'b0;
        polQ[c]     <= 1'b0;
        srcQ[c]     <= 1'b0;
        bitQ[c]     <= '0;
        cntQ[c]     <= '0;
      end else if (ctxRst[c]) begin
        busyVec[c] <= 1'b0;
        cntQ[c]    <= '0;
      end else if (hit) begin
        if (strobe.start) begin
          busyVec[c]  <= 1'b1;
          isDelayQ[c] <= (reqKind == REQ_DELAY);
          polQ[c]     <= (reqKind == REQ_WAIT_HI);
          srcQ[c]     <= reqSrc;
          bitQ[c]     <= reqBit;
          cntQ[c]     <= (reqKind == REQ_DELAY) ? reqCount : '0;
        end else if (strobe.finish) begin
          busyVec[c] <= 1'b0;
          cntQ[c]    <= '0;
        end else if (strobe.step) begin
          cntQ[c] <= cntQ[c] - CNTW_P'(1);
        end
      end
    end
  end

  assign selBusy    = busyVec[selCtx];
  assign selIsDelay = isDelayQ[selCtx];
  assign selPol     = polQ[selCtx];
  assign selSrc     = srcQ[selCtx];
  assign selBit     = bitQ[selCtx];
  assign selCnt     = cntQ[selCtx];
endmodule

// File: rtl/ctx_stall_ctl.sv
module ctx_stall_ctl
  import ctx_stall_pkg::*;
#(
  parameter int NCTX_P = NCTX,
  parameter int DW_P   = DW,
  parameter int CNTW_P = CNTW,
  localparam int CW_P  = $clog2(NCTX_P),
  localparam int BW_P  = $clog2(DW_P)
) (
  input  logic              slotValid,
  input  logic [CW_P-1:0]   slotCtx,
  input  logic [1:0]        reqKind,
  input  logic              reqSrc,
  input  logic [BW_P-1:0]   reqBit,
  input  logic [CNTW_P-1:0] reqCount,
  input  logic [DW_P-1:0]   portIn,
  input  logic [DW_P-1:0]   sharedReg,
  input  logic              selBusy,
  input  logic              selIsDelay,
  input  logic              selPol,
  input  logic              selSrc,
  input  logic [BW_P-1:0]   selBit,
  input  logic [CNTW_P-1:0] selCnt,
  output stallStrobe_t      strobe
);
  logic [DW_P-1:0] heldWord, newWord;
  logic            heldBitVal, newBitVal;

  assign heldWord   = selSrc ? sharedReg : portIn;
  assign newWord    = reqSrc ? sharedReg : portIn;
  assign heldBitVal = heldWord[selBit];
  assign newBitVal  = newWord[reqBit];

  always_comb begin
    strobe     = '0;
    strobe.ctx = slotCtx;
    if (slotValid) begin
      if (selBusy) begin
        if (selIsDelay) begin
          if (selCnt == CNTW_P'(1)) strobe.finish = 1'b1;
          else                      strobe.step   = 1'b1;
        end else if (heldBitVal == selPol) begin
          strobe.finish = 1'b1;
        end
      end else begin
        case (reqKind)
          REQ_WAIT_LO: strobe.start = newBitVal;
          REQ_WAIT_HI: strobe.start = !newBitVal;
          REQ_DELAY:   strobe.start = (reqCount != '0);
          default:     strobe.start = 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/ctx_stall_ctrl.sv
module ctx_stall_ctrl
  import ctx_stall_pkg::*;
#(
  parameter int NCTX_P = NCTX,
  parameter int DW_P   = DW,
  parameter int CNTW_P = CNTW,
  localparam int CW_P  = $clog2(NCTX_P),
  localparam int BW_P  = $clog2(DW_P)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NCTX_P-1:0] ctxRst,
  input  logic              slotValid,
  input  logic [CW_P-1:0]   slotCtx,
  input  logic [1:0]        reqKind,
  input  logic              reqSrc,
  input  logic [BW_P-1:0]   reqBit,
  input  logic [CNTW_P-1:0] reqCount,
  input  logic [DW_P-1:0]   portIn,
  input  logic [DW_P-1:0]   sharedReg,
  output logic [NCTX_P-1:0] holdOut
);
  stallStrobe_t      strobe;
  logic              selBusy, selIsDelay, selPol, selSrc;
  logic [BW_P-1:0]   selBit;
  logic [CNTW_P-1:0] selCnt;

  ctx_stall_ctl #(.NCTX_P(NCTX_P), .DW_P(DW_P), .CNTW_P(CNTW_P)) u_ctl (
    .slotValid(slotValid), .slotCtx(slotCtx), .reqKind(reqKind),
    .reqSrc(reqSrc), .reqBit(reqBit), .reqCount(reqCount),
    .portIn(portIn), .sharedReg(sharedReg),
    .selBusy(selBusy), .selIsDelay(selIsDelay), .selPol(selPol),
    .selSrc(selSrc), .selBit(selBit), .selCnt(selCnt),
    .strobe(strobe)
  );

  ctx_stall_dp #(.NCTX_P(NCTX_P), .DW_P(DW_P), .CNTW_P(CNTW_P)) u_dp (
    .clk(clk), .rstN(rstN), .ctxRst(ctxRst), .strobe(strobe),
    .selCtx(slotCtx), .reqKind(reqKind), .reqSrc(reqSrc),
    .reqBit(reqBit), .reqCount(reqCount), .busyVec(holdOut),
    .selBusy(selBusy), .selIsDelay(selIsDelay), .selPol(selPol),
    .selSrc(selSrc), .selBit(selBit), .selCnt(selCnt)
  );
endmodule

// File: rtl/ctx_stall_chk.sv
module ctx_stall_chk #(
  parameter int NCTX_P = 8,
  parameter int DW_P   = 8,
  parameter int CNTW_P = 8,
  localparam int CW_P  = $clog2(NCTX_P),
  localparam int BW_P  = $clog2(DW_P)
) (
  input logic              clk,
  input logic              rstN,
  input logic [NCTX_P-1:0] ctxRst,
  input logic              slotValid,
  input logic [CW_P-1:0]   slotCtx,
  input logic [1:0]        reqKind,
  input logic              reqSrc,
  input logic [BW_P-1:0]   reqBit,
  input logic [CNTW_P-1:0] reqCount,
  input logic [DW_P-1:0]   portIn,
  input logic [DW_P-1:0]   sharedReg,
  input logic [NCTX_P-1:0] holdOut
);
  AST_RESET_IDLE: assert property (@(posedge clk) !rstN |=> holdOut == '0); // R1

  AST_IDLE_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    (!slotValid && ctxRst == '0) |=> $stable(holdOut)); // R12

  for (genvar c = 0; c < NCTX_P; c++) begin : g_chk
    logic mine;
    assign mine = slotValid && (slotCtx == CW_P'(c));

    AST_OTHER_CTX_STABLE: assert property (@(posedge clk) disable iff (!rstN)
      (!mine && !ctxRst[c]) |=> $stable(holdOut[c])); // R9

    AST_CTX_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
      ctxRst[c] |=> !holdOut[c]); // R11

    AST_DELAY_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      (mine && !holdOut[c] && reqKind == 2'd3 && reqCount == '0) |=> !holdOut[c]); // R7

    AST_DELAY_START: assert property (@(posedge clk) disable iff (!rstN)
      (mine && !holdOut[c] && !ctxRst[c] && reqKind == 2'd3 && reqCount != '0)
      |=> holdOut[c]); // R6

    AST_WAIT_LO_MET: assert property (@(posedge clk) disable iff (!rstN)
      (mine && !holdOut[c] && reqKind == 2'd1 &&
       !(reqSrc ? sharedReg[reqBit] : portIn[reqBit])) |=> !holdOut[c]); // R2
  end
endmodule

bind ctx_stall_ctrl ctx_stall_chk #(.NCTX_P(NCTX_P), .DW_P(DW_P), .CNTW_P(CNTW_P)) u_chk (
  .clk(clk), .rstN(rstN), .ctxRst(ctxRst), .slotValid(slotValid),
  .slotCtx(slotCtx), .reqKind(reqKind), .reqSrc(reqSrc), .reqBit(reqBit),
  .reqCount(reqCount), .portIn(portIn), .sharedReg(sharedReg),
  .holdOut(holdOut)
);

// File: tb/ctx_stall_ctrl_bench.sv
module ctx_stall_ctrl_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] ctxRst = '0;
  logic       slotValid = 1'b0;
  logic [2:0] slotCtx = '0;
  logic [1:0] reqKind = '0;
  logic       reqSrc = 1'b0;
  logic [2:0] reqBit = '0;
  logic [7:0] reqCount = '0;
  logic [7:0] portIn = '0;
  logic [7:0] sharedReg = '0;
  logic [7:0] holdOut;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  ctx_stall_ctrl u_ctx_stall_ctrl (
    .clk(clk), .rstN(rstN), .ctxRst(ctxRst), .slotValid(slotValid),
    .slotCtx(slotCtx), .reqKind(reqKind), .reqSrc(reqSrc), .reqBit(reqBit),
    .reqCount(reqCount), .portIn(portIn), .sharedReg(sharedReg),
    .holdOut(holdOut)
  );

  typedef struct packed {
    logic       v;
    logic [2:0] ctx;
    logic [1:0] kind;
    logic       src;
    logic [2:0] bsel;
    logic [7:0] cnt;
    logic [7:0] port;
    logic [7:0] shr;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NVEC = 17;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 3'd2, 2'd1, 1'b0, 3'd3, 8'd0, 8'h08, 8'h00, 8'h04, 4'd3},  // R3 ctx2 waits low
    '{1'b1, 3'd5, 2'd3, 1'b0, 3'd0, 8'd2, 8'h08, 8'h00, 8'h24, 4'd6},  // R6 ctx5 delay 2
    '{1'b1, 3'd2, 2'd2, 1'b1, 3'd0, 8'd0, 8'h08, 8'h01, 8'h24, 4'd10}, // R10 new fields ignored
    '{1'b1, 3'd1, 2'd0, 1'b0, 3'd0, 8'd0, 8'h00, 8'h00, 8'h24, 4'd8},  // R8 bit low in other slot
    '{1'b1, 3'd5, 2'd0, 1'b0, 3'd0, 8'd0, 8'h00, 8'h00, 8'h24, 4'd6},  // R6 first held slot
    '{1'b1, 3'd2, 2'd0, 1'b0, 3'd0, 8'd0, 8'h00, 8'h00, 8'h20, 4'd3},  // R3 release in own slot
    '{1'b1, 3'd5, 2'd0, 1'b0, 3'd0, 8'd0, 8'h00, 8'h00, 8'h00, 4'd6},  // R6 second held slot ends
    '{1'b1, 3'd0, 2'd2, 1'b1, 3'd7, 8'd0, 8'hFF, 8'h7F, 8'h01, 4'd4},  // R4 ctx0 waits high
    '{1'b1, 3'd3, 2'd1, 1'b1, 3'd0, 8'd0, 8'hFF, 8'h7E, 8'h01, 4'd2},  // R2 already low
    '{1'b1, 3'd0, 2'd0, 1'b0, 3'd0, 8'd0, 8'h00, 8'hFF, 8'h00, 4'd5},  // R5 shared source used
    '{1'b1, 3'd4, 2'd2, 1'b0, 3'd1, 8'd0, 8'h02, 8'h00, 8'h00, 4'd2},  // R2 already high
    '{1'b1, 3'd7, 2'd3, 1'b0, 3'd0, 8'd0, 8'h00, 8'h00, 8'h00, 4'd7},  // R7 delay 0
    '{1'b1, 3'd6, 2'd3, 1'b0, 3'd0, 8'd1, 8'h00, 8'h00, 8'h40, 4'd6},  // R6 delay 1
    '{1'b0, 3'd6, 2'd3, 1'b0, 3'd0, 8'd9, 8'hFF, 8'hFF, 8'h40, 4'd12}, // R12 no slot
    '{1'b1, 3'd6, 2'd0, 1'b0, 3'd0, 8'd0, 8'h00, 8'h00, 8'h00, 4'd6},  // R6 delay 1 ends
    '{1'b1, 3'd4, 2'd2, 1'b1, 3'd2, 8'd0, 8'hFF, 8'h00, 8'h10, 4'd5},  // R5 port high ignored
    '{1'b1, 3'd4, 2'd0, 1'b0, 3'd0, 8'd0, 8'h00, 8'h04, 8'h00, 4'd5}   // R5 shared bit releases
  };

  task automatic slot(input logic v, input logic [2:0] ctx, input logic [1:0] kind,
                      input logic src, input logic [2:0] bsel, input logic [7:0] cnt,
                      input logic [7:0] port, input logic [7:0] shr);
    slotValid = v; slotCtx = ctx; reqKind = kind; reqSrc = src;
    reqBit = bsel; reqCount = cnt; portIn = port; sharedReg = shr;
    @(posedge clk);
    #2;
  endtask

  task automatic check(input string tag, input logic [7:0] exp);
    checks++;
    if (holdOut !== exp) begin
      errors++;
      $display("FAIL %s holdOut actual=%02h expected=%02h", tag, holdOut, exp);
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1 during reset", 8'h00);
    rstN = 1'b1;
    @(posedge clk);
    #2;
    check("R1 after reset", 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      slot(VECS[i].v, VECS[i].ctx, VECS[i].kind, VECS[i].src, VECS[i].bsel,
           VECS[i].cnt, VECS[i].port, VECS[i].shr);
      checks++;
      if (holdOut !== VECS[i].exp) begin
        errors++;
        $display("FAIL R%0d vector %0d holdOut actual=%02h expected=%02h",
                 VECS[i].req, i, holdOut, VECS[i].exp);
      end
    end

    // R11: context reset clears a pending delay, and beats a request in the same cycle
    slot(1'b1, 3'd3, 2'd3, 1'b0, 3'd0, 8'd5, 8'h00, 8'h00);
    check("R11 delay pending", 8'h08);
    ctxRst = 8'h08;
    slot(1'b1, 3'd3, 2'd3, 1'b0, 3'd0, 8'd5, 8'h00, 8'h00);
    ctxRst = 8'h00;
    check("R11 context reset clears", 8'h00);

    // R1: global reset mid-wait
    slot(1'b1, 3'd2, 2'd2, 1'b0, 3'd0, 8'd0, 8'h00, 8'h00);
    check("R4 wait high pending", 8'h04);
    rstN = 1'b0;
    slot(1'b0, 3'd0, 2'd0, 1'b0, 3'd0, 8'd0, 8'h00, 8'h00);
    check("R1 reset mid-wait", 8'h00);
    rstN = 1'b1;
    slot(1'b0, 3'd0, 2'd0, 1'b0, 3'd0, 8'd0, 8'h00, 8'h00);

    // R6: maximum delay of 255 own slots, interleaved with another context
    slot(1'b1, 3'd1, 2'd3, 1'b0, 3'd0, 8'd255, 8'h00, 8'h00);
    for (int k = 1; k < 255; k++) begin
      slot(1'b1, 3'd1, 2'd0, 1'b0, 3'd0, 8'd0, 8'h00, 8'h00);
      slot(1'b1, 3'd6, 2'd0, 1'b0, 3'd0, 8'd0, 8'h00, 8'h00);
    end
    check("R6 delay 255 held after 254 slots", 8'h02);
    slot(1'b1, 3'd1, 2'd0, 1'b0, 3'd0, 8'd0, 8'h00, 8'h00);
    check("R6 delay 255 released", 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule